// File: doc/BRIEF.md
# Program Address Sequencer with Nibble-RAM Call Stack

This block produces the instruction-fetch address for a small stack-oriented 4-bit processor. A 12-bit program counter walks a 4096-byte program store one byte per instruction cycle. An instruction decoder hands the block one command at a time: step, jump, subroutine call, short call into the low 512 bytes of program space, return, interrupt return, constant-table fetch, and push or pop of a loop value. Eight prioritised interrupt request lines can redirect the counter to fixed entry slots.

Return addresses and loop values are 12 bits wide. They are stored in the processor's shared 4-bit data RAM. Each entry fills three consecutive nibbles of a four-nibble slot, and an 8-bit return pointer selects the slot. Because the RAM port moves one nibble per cycle, stack operations take several cycles. During that time the block lowers `cmd_ready`, and the decoder holds its command until it is accepted.

Top module: `prog_sequencer`

## Requirements
- R1: After reset, `fetch_addr` is 000h, `ret_ptr` equals parameter `RP_BASE` (default 04h), `pop_data` is 000h, no interrupt level is in service, `busy` is 0 and `cmd_ready` is 1.
- R2: Command code 0 (step) advances the counter by one, wrapping from FFFh to 000h. Unused codes 9 to 15 behave as step.
- R3: Command code 1 (jump) loads `target` into the counter and leaves `ret_ptr` and the RAM untouched.
- R4: A push writes the 12-bit value as three nibbles, least significant first, at `ret_ptr`, `ret_ptr`+1 and `ret_ptr`+2, one per cycle. It then raises `ret_ptr` by 4. `ram_we` and `ram_re` are never high together.
- R5: Command code 2 (call) loads `target` and pushes the counter plus one. Command code 3 (short call) loads `scall_idx`×8 and pushes the counter plus one.
- R6: Command code 4 (return) reads the three nibbles below `ret_ptr`, lowers `ret_ptr` by 4, and loads the reassembled value into the counter.
- R7: Command code 7 pushes `target` as a loop value and advances the counter. Command code 8 pops an entry into `pop_data` and advances the counter.
- R8: Command code 6 (table fetch) drives `target` on `fetch_addr` with `table_fetch` high for exactly one cycle. After that cycle, `fetch_addr` shows the old counter plus one.
- R9: A taken interrupt of level L pushes the current counter and jumps to (L+1)×40h for L of 0 to 6, and to 1E0h for L = 7. When several requests are pending, the highest level wins. `irq_ack` pulses one-hot for the taken level, in the cycle it is taken.
- R10: A pending request is taken only while the block is idle, and only if its level is above every level in service. When a request is taken in an idle cycle, a command offered in that same cycle is not accepted.
- R11: Command code 5 (interrupt return) acts as a return and also clears the highest level in service. This lets lower pending requests be taken afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Decoder offers a command |
| cmd | input | 4 | Command code |
| target | input | 12 | Jump, call or table address, or loop value |
| scall_idx | input | 6 | Short-call slot number |
| irq_req | input | 8 | Interrupt requests, bit 7 highest |
| ram_rdata | input | 4 | RAM read data, one cycle after the read |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| busy | output | 1 | Stack transfer or table cycle in progress |
| fetch_addr | output | 12 | Program memory address |
| table_fetch | output | 1 | Current fetch is a table constant |
| irq_ack | output | 8 | One-hot acknowledge of the taken level |
| ret_ptr | output | 8 | Return stack pointer |
| pop_data | output | 12 | Last popped loop value |
| ram_addr | output | 8 | RAM nibble address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 4 | RAM write data |
| ram_re | output | 1 | RAM read enable |

## Verification
On every cycle, the assertions check the following:
- the one-cycle effects of step, jump and table fetch on the fetch address;
- that acknowledges are one-hot and only appear when idle;
- that the pointer stays slot-aligned;
- that reads and writes never collide.

Only the bench's scenarios can show the rest:
- the values that travel through the RAM and come back on return;
- the vector chosen among several requests;
- refusal of lower-level requests while nested;
- late entry of a held request once an interrupt return clears its blocker.

// File: rtl/pcs_pkg.sv
`timescale 1ns/1ps
package pcs_pkg;
  typedef enum logic [3:0] {
    CMD_STEP   = 4'd0,
    CMD_BRANCH = 4'd1,
    CMD_CALL   = 4'd2,
    CMD_SCALL  = 4'd3,
    CMD_RET    = 4'd4,
    CMD_RETI   = 4'd5,
    CMD_TABLE  = 4'd6,
    CMD_PUSHD  = 4'd7,
    CMD_POPD   = 4'd8
  } pcs_cmd_e;

  typedef enum logic [1:0] {
    POPK_RET  = 2'd0,
    POPK_RETI = 2'd1,
    POPK_DATA = 2'd2
  } pcs_popk_e;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_PUSH = 2'd1,
    RS_POP  = 2'd2
  } pcs_rs_e;
endpackage

// File: rtl/pcs_irq_arb.sv
`timescale 1ns/1ps
module pcs_irq_arb #(
  parameter int LEVELS = 8,
  localparam int LW = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [LEVELS-1:0] irq_req,
  input  logic              take_en,
  input  logic              clr_top,
  output logic              take,
  output logic [LW-1:0]     take_lvl,
  output logic [LEVELS-1:0] irq_ack
);
  logic [LEVELS-1:0] isr_q, isr_d;
  logic              pend_any, srv_any;
  logic [LW-1:0]     pend_lvl, srv_lvl;

  always_comb begin
    pend_any = 1'b0;
    srv_any  = 1'b0;
    pend_lvl = '0;
    srv_lvl  = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (irq_req[i]) begin
        pend_any = 1'b1;
        pend_lvl = LW'(i);
      end
      if (isr_q[i]) begin
        srv_any = 1'b1;
        srv_lvl = LW'(i);
      end
    end
  end

  always_comb begin
    take     = take_en && pend_any && (!srv_any || (pend_lvl > srv_lvl));
    take_lvl = pend_lvl;
    irq_ack  = '0;
    if (take) irq_ack[pend_lvl] = 1'b1;
    isr_d = isr_q;
    if (take) isr_d[pend_lvl] = 1'b1;
    if (clr_top && srv_any) isr_d[srv_lvl] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= isr_d;
  end

  p_ack_onehot_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(irq_ack));
  p_ack_pending_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_ack & ~irq_req) == '0);
endmodule

// File: rtl/pcs_rstack.sv
`timescale 1ns/1ps
module pcs_rstack #(
  parameter int          PC_W    = 12,
  parameter int          NIB_W   = 4,
  parameter int          AW      = 8,
  parameter logic [AW-1:0] RP_BASE = 8'h04,
  localparam int NIBS = PC_W / NIB_W,
  localparam int SLOT = 1 << $clog2(NIBS),
  localparam int CW   = $clog2(NIBS + 1)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             push_start,
  input  logic [PC_W-1:0]  push_val,
  input  logic             pop_start,
  input  logic [NIB_W-1:0] ram_rdata,
  output logic             busy,
  output logic             pop_done,
  output logic [PC_W-1:0]  pop_val,
  output logic [AW-1:0]    rp,
  output logic [AW-1:0]    ram_addr,
  output logic             ram_we,
  output logic [NIB_W-1:0] ram_wdata,
  output logic             ram_re
);
  import pcs_pkg::*;

  pcs_rs_e         mode_q, mode_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [AW-1:0]   rp_q, rp_d;
  logic [PC_W-1:0] val_q, val_d;
  logic [AW-1:0]   pop_base;

  assign pop_base = rp_q - AW'(SLOT);
  assign busy     = (mode_q != RS_IDLE);
  assign rp       = rp_q;

  always_comb begin
    pop_val = val_q;
    pop_val[(NIBS-1)*NIB_W +: NIB_W] = ram_rdata;
  end

  always_comb begin
    mode_d    = mode_q;
    cnt_d     = cnt_q;
    rp_d      = rp_q;
    val_d     = val_q;
    ram_addr  = rp_q;
    ram_we    = 1'b0;
    ram_re    = 1'b0;
    ram_wdata = '0;
    pop_done  = 1'b0;
    unique case (mode_q)
      RS_IDLE: begin
        if (push_start) begin
          mode_d = RS_PUSH;
          cnt_d  = '0;
          val_d  = push_val;
        end else if (pop_start) begin
          mode_d = RS_POP;
          cnt_d  = '0;
        end
      end
      RS_PUSH: begin
        ram_we    = 1'b1;
        ram_addr  = rp_q + AW'(cnt_q);
        ram_wdata = val_q[int'(cnt_q)*NIB_W +: NIB_W];
        if (cnt_q == CW'(NIBS-1)) begin
          mode_d = RS_IDLE;
          rp_d   = rp_q + AW'(SLOT);
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      RS_POP: begin
        ram_addr = pop_base + AW'(cnt_q);
        if (cnt_q < CW'(NIBS)) begin
          ram_re = 1'b1;
          if (cnt_q != '0)
            val_d[(int'(cnt_q)-1)*NIB_W +: NIB_W] = ram_rdata;
          cnt_d = cnt_q + CW'(1);
        end else begin
          pop_done = 1'b1;
          mode_d   = RS_IDLE;
          rp_d     = pop_base;
          cnt_d    = '0;
        end
      end
      default: mode_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RS_IDLE;
      cnt_q  <= '0;
      rp_q   <= RP_BASE;
      val_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      rp_q   <= rp_d;
      val_q  <= val_d;
    end
  end

  p_ptr_align_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    rp[1:0] == RP_BASE[1:0]);
  p_rw_excl_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !(ram_we && ram_re));
endmodule

// File: rtl/prog_sequencer.sv
`timescale 1ns/1ps
module prog_sequencer #(
  parameter int           PC_W      = 12,
  parameter int           NIB_W     = 4,
  parameter int           AW        = 8,
  parameter int           LEVELS    = 8,
  parameter int           ZP_W      = 9,
  parameter int           SLOT_SH   = 3,
  parameter int           VEC_SH    = 6,
  parameter logic [7:0]   RP_BASE   = 8'h04,
  localparam int IDX_W = ZP_W - SLOT_SH,
  localparam int LW    = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd,
  input  logic [PC_W-1:0]   target,
  input  logic [IDX_W-1:0]  scall_idx,
  input  logic [LEVELS-1:0] irq_req,
  input  logic [NIB_W-1:0]  ram_rdata,
  output logic              cmd_ready,
  output logic              busy,
  output logic [PC_W-1:0]   fetch_addr,
  output logic              table_fetch,
  output logic [LEVELS-1:0] irq_ack,
  output logic [AW-1:0]     ret_ptr,
  output logic [PC_W-1:0]   pop_data,
  output logic [AW-1:0]     ram_addr,
  output logic              ram_we,
  output logic [NIB_W-1:0]  ram_wdata,
  output logic              ram_re
);
  import pcs_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [PC_W-1:0] pc_q, pc_d, pc_inc;
  logic            tbl_q, tbl_d;
  logic [PC_W-1:0] tbl_addr_q, tbl_addr_d;
  pcs_popk_e       popk_q, popk_d;
  logic [PC_W-1:0] pop_data_q, pop_data_d;

  logic            idle, accept;
  logic            irq_take, clr_top;
  logic [LW-1:0]   take_lvl;
  logic            push_start, pop_start, rs_busy, pop_done;
  logic [PC_W-1:0] push_val, pop_val;

  function automatic logic [PC_W-1:0] vec_of(input logic [LW-1:0] lvl);
    if (lvl == LW'(LEVELS-1))
      return PC_W'((LEVELS << VEC_SH) - (1 << (VEC_SH-1)));
    return PC_W'((int'(lvl) + 1) << VEC_SH);
  endfunction

  pcs_irq_arb #(.LEVELS(LEVELS)) u_arb (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .irq_req  (irq_req),
    .take_en  (idle),
    .clr_top  (clr_top),
    .take     (irq_take),
    .take_lvl (take_lvl),
    .irq_ack  (irq_ack)
  );

  pcs_rstack #(.PC_W(PC_W), .NIB_W(NIB_W), .AW(AW), .RP_BASE(RP_BASE)) u_rs (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .push_start (push_start),
    .push_val   (push_val),
    .pop_start  (pop_start),
    .ram_rdata  (ram_rdata),
    .busy       (rs_busy),
    .pop_done   (pop_done),
    .pop_val    (pop_val),
    .rp         (ret_ptr),
    .ram_addr   (ram_addr),
    .ram_we     (ram_we),
    .ram_wdata  (ram_wdata),
    .ram_re     (ram_re)
  );

  assign idle        = !rs_busy && !tbl_q;
  assign busy        = !idle;
  assign cmd_ready   = idle && !irq_take;
  assign accept      = cmd_valid && cmd_ready;
  assign pc_inc      = pc_q + PC_W'(1);
  assign fetch_addr  = tbl_q ? tbl_addr_q : pc_q;
  assign table_fetch = tbl_q;
  assign pop_data    = pop_data_q;

  always_comb begin
    pc_d       = pc_q;
    tbl_d      = 1'b0;
    tbl_addr_d = tbl_addr_q;
    popk_d     = popk_q;
    pop_data_d = pop_data_q;
    push_start = 1'b0;
    push_val   = pc_q;
    pop_start  = 1'b0;
    clr_top    = 1'b0;
    if (irq_take) begin
      push_start = 1'b1;
      push_val   = pc_q;
      pc_d       = vec_of(take_lvl);
    end else if (accept) begin
      case (cmd)
        CMD_BRANCH: pc_d = target;
        CMD_CALL: begin
          push_start = 1'b1;
          push_val   = pc_inc;
          pc_d       = target;
        end
        CMD_SCALL: begin
          push_start = 1'b1;
          push_val   = pc_inc;
          pc_d       = PC_W'({scall_idx, {SLOT_SH{1'b0}}});
        end
        CMD_RET: begin
          pop_start = 1'b1;
          popk_d    = POPK_RET;
        end
        CMD_RETI: begin
          pop_start = 1'b1;
          popk_d    = POPK_RETI;
        end
        CMD_TABLE: begin
          tbl_d      = 1'b1;
          tbl_addr_d = target;
          pc_d       = pc_inc;
        end
        CMD_PUSHD: begin
          push_start = 1'b1;
          push_val   = target;
          pc_d       = pc_inc;
        end
        CMD_POPD: begin
          pop_start = 1'b1;
          popk_d    = POPK_DATA;
          pc_d      = pc_inc;
        end
        default: pc_d = pc_inc;
      endcase
    end
    if (pop_done) begin
      case (popk_q)
        POPK_RET:  pc_d = pop_val;
        POPK_RETI: begin
          pc_d    = pop_val;
          clr_top = 1'b1;
        end
        default:   pop_data_d = pop_val;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= '0;
      tbl_q      <= 1'b0;
      tbl_addr_q <= '0;
      popk_q     <= POPK_RET;
      pop_data_q <= '0;
    end else begin
      pc_q       <= pc_d;
      tbl_q      <= tbl_d;
      tbl_addr_q <= tbl_addr_d;
      popk_q     <= popk_d;
      pop_data_q <= pop_data_d;
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && cmd == CMD_STEP) |=> fetch_addr == $past(fetch_addr) + PC_W'(1));
  p_branch_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && cmd == CMD_BRANCH) |=> (fetch_addr == $past(target)) && !busy);
  p_table_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && cmd == CMD_TABLE) |=> table_fetch && fetch_addr == $past(target));
  p_no_ack_busy_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> irq_ack == '0);
endmodule

// File: tb/sim_prog_sequencer.sv
`timescale 1ns/1ps
module sim_prog_sequencer;
  import pcs_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [3:0]  cmd;
  logic [11:0] target;
  logic [5:0]  scall_idx;
  logic [7:0]  irq_req;
  logic [3:0]  ram_rdata;
  logic        cmd_ready, busy, table_fetch, ram_we, ram_re;
  logic [11:0] fetch_addr, pop_data;
  logic [7:0]  irq_ack, ret_ptr, ram_addr;
  logic [3:0]  ram_wdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  prog_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .target(target), .scall_idx(scall_idx), .irq_req(irq_req),
    .ram_rdata(ram_rdata), .cmd_ready(cmd_ready), .busy(busy),
    .fetch_addr(fetch_addr), .table_fetch(table_fetch), .irq_ack(irq_ack),
    .ret_ptr(ret_ptr), .pop_data(pop_data), .ram_addr(ram_addr),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_re(ram_re)
  );

  logic [3:0] mem [256];
  logic [3:0] rd_q;
  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    rd_q <= mem[ram_addr];
  end
  assign ram_rdata = rd_q;

  typedef struct packed {
    logic [3:0]  c;
    logic [11:0] tgt;
    logic [5:0]  idx;
    logic [11:0] e_pc;
    logic [7:0]  e_rp;
    logic [11:0] e_pd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 12'h000, 6'd0, 12'h001, 8'h04, 12'h000},
    '{4'd0, 12'h000, 6'd0, 12'h002, 8'h04, 12'h000},
    '{4'd1, 12'h345, 6'd0, 12'h345, 8'h04, 12'h000},
    '{4'd2, 12'h7A0, 6'd0, 12'h7A0, 8'h08, 12'h000},
    '{4'd0, 12'h000, 6'd0, 12'h7A1, 8'h08, 12'h000},
    '{4'd3, 12'h000, 6'd3, 12'h018, 8'h0C, 12'h000},
    '{4'd4, 12'h000, 6'd0, 12'h7A2, 8'h08, 12'h000},
    '{4'd4, 12'h000, 6'd0, 12'h346, 8'h04, 12'h000},
    '{4'd7, 12'hABC, 6'd0, 12'h347, 8'h08, 12'h000},
    '{4'd8, 12'h000, 6'd0, 12'h348, 8'h04, 12'hABC},
    '{4'd1, 12'hFFF, 6'd0, 12'hFFF, 8'h04, 12'hABC},
    '{4'd0, 12'h000, 6'd0, 12'h000, 8'h04, 12'hABC}
  };

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'd0:       return "R2";
      4'd1:       return "R3";
      4'd2, 4'd3: return "R5";
      4'd4:       return "R6";
      default:    return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20; k++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic do_cmd(input logic [3:0] c, input logic [11:0] t, input logic [5:0] ix);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; target = t; scall_idx = ix;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic raise_irq(input logic [7:0] req, input logic [7:0] after);
    @(negedge clk);
    irq_req = req;
    @(posedge clk);
    @(negedge clk);
    irq_req = after;
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 4'h0;
    cmd_valid = 1'b0; cmd = 4'd0; target = '0; scall_idx = '0; irq_req = '0;
    do_reset();

    // R1 reset state
    chk("R1", "fetch_addr", fetch_addr, 12'h000);
    chk("R1", "ret_ptr", ret_ptr, 8'h04);
    chk("R1", "pop_data", pop_data, 12'h000);
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "cmd_ready", cmd_ready, 1'b1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      do_cmd(VECS[i].c, VECS[i].tgt, VECS[i].idx);
      chk(req_of(VECS[i].c), "fetch_addr", fetch_addr, VECS[i].e_pc);
      chk(req_of(VECS[i].c), "ret_ptr", ret_ptr, VECS[i].e_rp);
      chk(req_of(VECS[i].c), "pop_data", pop_data, VECS[i].e_pd);
    end

    // R8 table fetch
    do_reset();
    @(negedge clk);
    cmd_valid = 1'b1; cmd = 4'd6; target = 12'h5A5;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R8", "table addr", fetch_addr, 12'h5A5);
    chk("R8", "table_fetch", table_fetch, 1'b1);
    @(negedge clk);
    chk("R8", "after table", fetch_addr, 12'h001);
    chk("R8", "table_fetch low", table_fetch, 1'b0);

    // R4 nibble layout of a call
    do_cmd(4'd1, 12'h2CD, 6'd0);
    do_cmd(4'd2, 12'h100, 6'd0);
    chk("R4", "nib0", mem[4], 4'hE);
    chk("R4", "nib1", mem[5], 4'hC);
    chk("R4", "nib2", mem[6], 4'h2);
    chk("R4", "ret_ptr", ret_ptr, 8'h08);

    // R9 level 2 interrupt
    @(negedge clk);
    irq_req = 8'h04;
    #1 chk("R9", "ack", irq_ack, 8'h04);
    @(posedge clk);
    @(negedge clk);
    irq_req = 8'h00;
    wait_idle();
    chk("R9", "vector 2", fetch_addr, 12'h0C0);
    chk("R9", "ret_ptr", ret_ptr, 8'h0C);
    chk("R9", "pushed", {mem[10], mem[9], mem[8]}, 12'h100);

    // R10 lower level ignored while level 2 in service
    @(negedge clk);
    irq_req = 8'h02;
    #1 chk("R10", "no ack", irq_ack, 8'h00);
    do_cmd(4'd0, 12'h000, 6'd0);
    chk("R10", "lower ignored", fetch_addr, 12'h0C1);
    chk("R10", "ret_ptr", ret_ptr, 8'h0C);

    // R10 higher level nests
    raise_irq(8'h22, 8'h02);
    chk("R10", "nested vector 5", fetch_addr, 12'h180);
    chk("R10", "ret_ptr", ret_ptr, 8'h10);

    // R11 returns
    do_cmd(4'd5, 12'h000, 6'd0);
    chk("R11", "reti to 0C1", fetch_addr, 12'h0C1);
    chk("R11", "ret_ptr", ret_ptr, 8'h0C);
    repeat (2) @(negedge clk);
    chk("R11", "level 1 still blocked", fetch_addr, 12'h0C1);
    do_cmd(4'd5, 12'h000, 6'd0);
    chk("R11", "reti to 100", fetch_addr, 12'h100);
    @(posedge clk);
    @(negedge clk);
    irq_req = 8'h00;
    wait_idle();
    chk("R11", "level 1 taken after clear", fetch_addr, 12'h080);
    chk("R11", "ret_ptr", ret_ptr, 8'h0C);
    do_cmd(4'd5, 12'h000, 6'd0);
    chk("R6", "back to 100", fetch_addr, 12'h100);

    // R9 priority and top vector
    @(negedge clk);
    irq_req = 8'h48;
    #1 chk("R9", "highest ack", irq_ack, 8'h40);
    @(posedge clk);
    @(negedge clk);
    irq_req = 8'h00;
    wait_idle();
    chk("R9", "vector 6", fetch_addr, 12'h1C0);
    raise_irq(8'h80, 8'h00);
    chk("R9", "vector 7", fetch_addr, 12'h1E0);
    chk("R9", "ret_ptr", ret_ptr, 8'h10);
    do_cmd(4'd5, 12'h000, 6'd0);
    do_cmd(4'd5, 12'h000, 6'd0);
    chk("R6", "unwound", fetch_addr, 12'h100);
    chk("R6", "ret_ptr", ret_ptr, 8'h08);

    // R10 interrupt beats a command in the same idle cycle
    @(negedge clk);
    cmd_valid = 1'b1; cmd = 4'd0; irq_req = 8'h01;
    #1 chk("R10", "cmd_ready low", cmd_ready, 1'b0);
    @(posedge clk);
    @(negedge clk);
    irq_req = 8'h00;
    for (int k = 0; k < 20; k++) begin
      if (cmd_ready) break;
      @(negedge clk);
    end
    chk("R10", "vector 0 before step", fetch_addr, 12'h040);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10", "step after entry", fetch_addr, 12'h041);
    do_cmd(4'd5, 12'h000, 6'd0);
    chk("R11", "final return", fetch_addr, 12'h100);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule